// File: doc/BRIEF.md
# Channel-to-Stream Protocol Bridge

This block joins one host-link channel to one hardware compute task. The channel uses a two-phase protocol in each direction: the sending side first raises an announce carrying a word count, an offset and a flag telling whether more transactions follow. The receiving side grants it with an acknowledge, and only then do data words move under a valid/ready handshake. The task sees none of this. It has a plain inbound word stream, a plain outbound word stream and a control stream, and each of these uses a valid/ready handshake.

The inbound path has three states: RX_IDLE, RX_GRANT and RX_MOVE. It grants each announce, passes exactly the announced number of words to the task, and reports the offset and the more-follows flag on status ports. If the channel withdraws its announce before every word has arrived, an error flag is raised. The outbound path has three states: TX_IDLE, TX_ANNOUNCE and TX_MOVE. It takes a word count from the task's control stream, announces a transaction of that length (offset 0, last flag 1), holds the announce until the channel grants it, and then drains exactly that many task output words. The two paths are independent, so one bridge instance serves one channel of a multi-channel link.

Inbound transitions: RX_IDLE to RX_GRANT when an announce is seen. RX_GRANT to RX_IDLE for a zero count, otherwise RX_GRANT to RX_MOVE. RX_MOVE to RX_IDLE on the final word, or early when the announce drops. Outbound transitions: TX_IDLE to TX_ANNOUNCE when a control word is taken. TX_ANNOUNCE to TX_IDLE when the grant arrives with a zero count, otherwise TX_ANNOUNCE to TX_MOVE. TX_MOVE to TX_IDLE on the final word.

Top module: `chan_task_bridge`

## Requirements
- R1: After reset, rx_ack, rx_data_rdy, task_in_vld, tx_req, tx_data_vld, task_out_rdy and stat_rx_err are 0, and ctl_rdy is 1.
- R2: An announce (rx_req high in RX_IDLE) is granted by rx_ack one cycle later, for exactly one cycle. rx_data_rdy stays 0 until the grant has been given.
- R3: In RX_MOVE, rx_data passes to task_in_data in arrival order, and rx_data_rdy follows task_in_rdy. Exactly rx_len words are passed, after which rx_data_rdy returns to 0.
- R4: If rx_req falls in RX_MOVE before the last word, stat_rx_err becomes 1 and stays 1 until the next announce is granted, which clears it to 0.
- R5: stat_rx_off and stat_rx_more hold the rx_off and rx_more values of the most recently accepted announce. The offset does not change the order or count of the forwarded words.
- R6: An announce with rx_len = 0 is granted and returns to RX_IDLE without raising rx_data_rdy or task_in_vld.
- R7: ctl_rdy is 1 only in TX_IDLE. A control word taken on ctl_vld is followed by tx_req in the next cycle.
- R8: From TX_ANNOUNCE until the grant, tx_req stays 1 with tx_len equal to the taken ctl_len, tx_off = 0 and tx_last = 1. During that time task_out_rdy stays 0.
- R9: After tx_ack, exactly tx_len task output words are sent in order on tx_data, with task_out_rdy following tx_data_rdy. tx_req then falls and no further task word is taken. A zero count ends the transaction at the grant.
- R10: Inbound and outbound transactions run concurrently without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_req | input | 1 | Inbound announce, held through the transaction |
| rx_len | input | LEN_W | Inbound word count |
| rx_off | input | OFF_W | Inbound offset |
| rx_more | input | 1 | Inbound more-transactions-follow flag |
| rx_ack | output | 1 | Inbound grant pulse |
| rx_data | input | DATA_W | Inbound word |
| rx_data_vld | input | 1 | Inbound word valid |
| rx_data_rdy | output | 1 | Inbound word ready |
| stat_rx_off | output | OFF_W | Offset of last accepted announce |
| stat_rx_more | output | 1 | More flag of last accepted announce |
| stat_rx_err | output | 1 | Early end of an inbound transaction |
| tx_req | output | 1 | Outbound announce |
| tx_len | output | LEN_W | Outbound word count |
| tx_off | output | OFF_W | Outbound offset, always 0 |
| tx_last | output | 1 | Outbound last flag, always 1 |
| tx_ack | input | 1 | Outbound grant |
| tx_data | output | DATA_W | Outbound word |
| tx_data_vld | output | 1 | Outbound word valid |
| tx_data_rdy | input | 1 | Outbound word ready |
| task_in_data | output | DATA_W | Word to task |
| task_in_vld | output | 1 | Word to task valid |
| task_in_rdy | input | 1 | Task accepts word |
| task_out_data | input | DATA_W | Word from task |
| task_out_vld | input | 1 | Word from task valid |
| task_out_rdy | output | 1 | Bridge takes task word |
| ctl_len | input | LEN_W | Outbound count from task |
| ctl_vld | input | 1 | Control word valid |
| ctl_rdy | output | 1 | Control word ready |

## Verification
The assertions rely on the channel keeping rx_req high from its announce until the last inbound word has been taken, and on no inbound valid word appearing once rx_req has dropped. They also rely on tx_ack being raised only while tx_req is high. The stimulus tasks drop rx_req one cycle after the final transfer, or deliberately mid-stream in the early-end test. They pulse tx_ack for a single cycle only after tx_req has been observed, and they vary the readiness on both the task side and the channel side with rotating patterns.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_GRANT = 2'd1,
        RX_MOVE  = 2'd2
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE     = 2'd0,
        TX_ANNOUNCE = 2'd1,
        TX_MOVE     = 2'd2
    } tx_state_t;
endpackage

// File: rtl/ctb_rx_path.sv
module ctb_rx_path
    import ctb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    parameter int OFF_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_req,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic [OFF_W-1:0]  rx_off,
    input  logic              rx_more,
    output logic              rx_ack,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_data_vld,
    output logic              rx_data_rdy,
    output logic [DATA_W-1:0] task_in_data,
    output logic              task_in_vld,
    input  logic              task_in_rdy,
    output logic [OFF_W-1:0]  stat_off,
    output logic              stat_more,
    output logic              stat_err
);
    rx_state_t        state_q, state_d;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    logic             take;
    logic             final_word;

    assign take       = (state_q == RX_MOVE) && rx_data_vld && task_in_rdy;
    assign final_word = ((cnt_q + 1'b1) == len_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (rx_req) state_d = RX_GRANT;
            RX_GRANT: state_d = (len_q == '0) ? RX_IDLE : RX_MOVE;
            RX_MOVE: begin
                if (take && final_word) state_d = RX_IDLE;
                else if (!rx_req)       state_d = RX_IDLE;
            end
            default:  state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RX_IDLE;
            len_q     <= '0;
            cnt_q     <= '0;
            stat_off  <= '0;
            stat_more <= 1'b0;
            stat_err  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == RX_IDLE && rx_req) begin
                len_q     <= rx_len;
                stat_off  <= rx_off;
                stat_more <= rx_more;
                stat_err  <= 1'b0;
                cnt_q     <= '0;
            end
            if (take) cnt_q <= cnt_q + 1'b1;
            if (state_q == RX_MOVE && !rx_req && !(take && final_word))
                stat_err <= 1'b1;
        end
    end

    always_comb begin
        rx_ack       = 1'b0;
        rx_data_rdy  = 1'b0;
        task_in_vld  = 1'b0;
        task_in_data = rx_data;
        unique case (state_q)
            RX_IDLE:  ;
            RX_GRANT: rx_ack = 1'b1;
            RX_MOVE: begin
                rx_data_rdy = task_in_rdy;
                task_in_vld = rx_data_vld;
            end
            default:  ;
        endcase
    end

    a_r2_grant_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ack |=> !rx_ack);
    a_r2_grant_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ack) |-> $past(rx_req));
    a_r3_count_below_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_MOVE) |-> (cnt_q < len_q));
    a_r4_early_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_MOVE && !rx_req && !take) |=> stat_err);
    a_r5_status_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_MOVE) |=> ($stable(stat_off) && $stable(stat_more)));
    a_r6_zero_len_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_GRANT && len_q == '0) |=> !rx_data_rdy && !task_in_vld);
endmodule

// File: rtl/ctb_tx_path.sv
module ctb_tx_path
    import ctb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    parameter int OFF_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  ctl_len,
    input  logic              ctl_vld,
    output logic              ctl_rdy,
    output logic              tx_req,
    output logic [LEN_W-1:0]  tx_len,
    output logic [OFF_W-1:0]  tx_off,
    output logic              tx_last,
    input  logic              tx_ack,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_data_vld,
    input  logic              tx_data_rdy,
    input  logic [DATA_W-1:0] task_out_data,
    input  logic              task_out_vld,
    output logic              task_out_rdy
);
    tx_state_t        state_q, state_d;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    logic             take;
    logic             final_word;

    assign take       = (state_q == TX_MOVE) && task_out_vld && tx_data_rdy;
    assign final_word = ((cnt_q + 1'b1) == len_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:     if (ctl_vld) state_d = TX_ANNOUNCE;
            TX_ANNOUNCE: if (tx_ack) state_d = (len_q == '0) ? TX_IDLE : TX_MOVE;
            TX_MOVE:     if (take && final_word) state_d = TX_IDLE;
            default:     state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            len_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TX_IDLE && ctl_vld) begin
                len_q <= ctl_len;
                cnt_q <= '0;
            end
            if (take) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        ctl_rdy      = 1'b0;
        tx_req       = 1'b0;
        tx_data_vld  = 1'b0;
        task_out_rdy = 1'b0;
        tx_len       = len_q;
        tx_off       = '0;
        tx_last      = 1'b1;
        tx_data      = task_out_data;
        unique case (state_q)
            TX_IDLE:     ctl_rdy = 1'b1;
            TX_ANNOUNCE: tx_req = 1'b1;
            TX_MOVE: begin
                tx_req       = 1'b1;
                tx_data_vld  = task_out_vld;
                task_out_rdy = tx_data_rdy;
            end
            default:     ;
        endcase
    end

    a_r7_ctl_opens_announce: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_vld && ctl_rdy) |=> tx_req);
    a_r8_announce_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_ANNOUNCE && !tx_ack) |=> (tx_req && $stable(tx_len)));
    a_r8_no_take_before_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_req) |-> !task_out_rdy);
    a_r9_count_below_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_MOVE) |-> (cnt_q < len_q));
endmodule

// File: rtl/chan_task_bridge.sv
module chan_task_bridge #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    parameter int OFF_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_req,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic [OFF_W-1:0]  rx_off,
    input  logic              rx_more,
    output logic              rx_ack,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_data_vld,
    output logic              rx_data_rdy,
    output logic [OFF_W-1:0]  stat_rx_off,
    output logic              stat_rx_more,
    output logic              stat_rx_err,
    output logic              tx_req,
    output logic [LEN_W-1:0]  tx_len,
    output logic [OFF_W-1:0]  tx_off,
    output logic              tx_last,
    input  logic              tx_ack,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_data_vld,
    input  logic              tx_data_rdy,
    output logic [DATA_W-1:0] task_in_data,
    output logic              task_in_vld,
    input  logic              task_in_rdy,
    input  logic [DATA_W-1:0] task_out_data,
    input  logic              task_out_vld,
    output logic              task_out_rdy,
    input  logic [LEN_W-1:0]  ctl_len,
    input  logic              ctl_vld,
    output logic              ctl_rdy
);
    ctb_rx_path #(.DATA_W(DATA_W), .LEN_W(LEN_W), .OFF_W(OFF_W)) rx_path_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_req       (rx_req),
        .rx_len       (rx_len),
        .rx_off       (rx_off),
        .rx_more      (rx_more),
        .rx_ack       (rx_ack),
        .rx_data      (rx_data),
        .rx_data_vld  (rx_data_vld),
        .rx_data_rdy  (rx_data_rdy),
        .task_in_data (task_in_data),
        .task_in_vld  (task_in_vld),
        .task_in_rdy  (task_in_rdy),
        .stat_off     (stat_rx_off),
        .stat_more    (stat_rx_more),
        .stat_err     (stat_rx_err)
    );

    ctb_tx_path #(.DATA_W(DATA_W), .LEN_W(LEN_W), .OFF_W(OFF_W)) tx_path_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl_len       (ctl_len),
        .ctl_vld       (ctl_vld),
        .ctl_rdy       (ctl_rdy),
        .tx_req        (tx_req),
        .tx_len        (tx_len),
        .tx_off        (tx_off),
        .tx_last       (tx_last),
        .tx_ack        (tx_ack),
        .tx_data       (tx_data),
        .tx_data_vld   (tx_data_vld),
        .tx_data_rdy   (tx_data_rdy),
        .task_out_data (task_out_data),
        .task_out_vld  (task_out_vld),
        .task_out_rdy  (task_out_rdy)
    );

    a_r10_ctl_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdy |-> !tx_req);
endmodule

// File: tb/chan_task_bridge_tb_top.sv
module chan_task_bridge_tb_top;
    localparam int DW = 32;
    localparam int LW = 8;
    localparam int OW = 8;
    localparam int NVEC = 8;
    // each vector: {inbound count, outbound count, readiness pattern}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'd1,  8'd1,  8'hFF}, {8'd4,  8'd3,  8'hA5},
        {8'd7,  8'd9,  8'h3C}, {8'd16, 8'd5,  8'h81},
        {8'd2,  8'd12, 8'h6E}, {8'd9,  8'd9,  8'hF0},
        {8'd5,  8'd1,  8'h55}, {8'd12, 8'd6,  8'hC3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          rx_req = 0, rx_more = 0, rx_data_vld = 0;
    logic [LW-1:0] rx_len = 0;
    logic [OW-1:0] rx_off = 0;
    logic [DW-1:0] rx_data = 0;
    logic          rx_ack, rx_data_rdy, stat_rx_more, stat_rx_err;
    logic [OW-1:0] stat_rx_off;
    logic          tx_req, tx_last, tx_data_vld;
    logic [LW-1:0] tx_len;
    logic [OW-1:0] tx_off;
    logic [DW-1:0] tx_data;
    logic          tx_ack = 0, tx_data_rdy = 0;
    logic [DW-1:0] task_in_data;
    logic          task_in_vld;
    logic          task_in_rdy = 0;
    logic [DW-1:0] task_out_data = 0;
    logic          task_out_vld = 0;
    logic          task_out_rdy;
    logic [LW-1:0] ctl_len = 0;
    logic          ctl_vld = 0;
    logic          ctl_rdy;

    chan_task_bridge #(.DATA_W(DW), .LEN_W(LW), .OFF_W(OW)) dut_i (.*);

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    logic [7:0] pat = 8'hFF;
    int tick = 0;
    int src_base = 0;
    int src_idx = 0;
    bit src_take = 0;
    logic [DW-1:0] rx_got[$];
    logic [DW-1:0] tx_got[$];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // readiness patterns and task word source, driven after the edge
    always @(posedge clk) begin
        #1;
        tick = tick + 1;
        task_in_rdy = pat[tick % 8];
        tx_data_rdy = pat[(tick + 3) % 8];
        if (src_take) src_idx = src_idx + 1;
        task_out_data = DW'(src_base + src_idx);
    end

    // monitors sample at the falling edge; a handshake seen here completes at the next rise
    always @(negedge clk) begin
        if (task_in_vld && task_in_rdy) rx_got.push_back(task_in_data);
        if (tx_data_vld && tx_data_rdy) tx_got.push_back(tx_data);
        src_take = task_out_vld && task_out_rdy;
    end

    task automatic rx_txn(input int len, input int off, input bit more, input int base, input int stop);
        rx_got.delete();
        @(posedge clk); #1;
        rx_req = 1; rx_len = LW'(len); rx_off = OW'(off); rx_more = more;
        @(negedge clk);
        chk(rx_ack == 0 && rx_data_rdy == 0, "R2 no grant or ready in announce cycle", rx_ack, 0);
        @(negedge clk);
        chk(rx_ack == 1, "R2 grant one cycle after announce", rx_ack, 1);
        if (len == 0) begin
            @(posedge clk); #1; rx_req = 0;
        end
        @(negedge clk);
        chk(rx_ack == 0, "R2 grant lasts one cycle", rx_ack, 0);
        chk(stat_rx_off == OW'(off), "R5 offset reported", stat_rx_off, off);
        chk(stat_rx_more == more, "R5 more flag reported", stat_rx_more, more);
        chk(stat_rx_err == 0, "R4 error cleared by new grant", stat_rx_err, 0);
        for (int i = 0; i < len && i < stop; i++) begin
            @(posedge clk); #1;
            rx_data_vld = 1; rx_data = DW'(base + i);
            do @(negedge clk); while (!rx_data_rdy);
        end
        if (len != 0) begin
            @(posedge clk); #1;
            rx_data_vld = 0; rx_req = 0;
        end
        @(negedge clk);
        @(negedge clk);
        chk(rx_data_rdy == 0, "R3 ready low after transaction", rx_data_rdy, 0);
        if (stop < len) begin
            chk(stat_rx_err == 1, "R4 early end flagged", stat_rx_err, 1);
        end else begin
            chk(stat_rx_err == 0, "R4 no error on full transfer", stat_rx_err, 0);
        end
    endtask

    task automatic rx_verify(input int n, input int base);
        chk(rx_got.size() == n, "R3 inbound word count", rx_got.size(), n);
        for (int i = 0; i < n && i < rx_got.size(); i++)
            chk(rx_got[i] == DW'(base + i), "R3 inbound word order", rx_got[i], base + i);
    endtask

    task automatic tx_txn(input int len, input int base);
        @(posedge clk); #1;
        tx_got.delete();
        src_base = base; src_idx = 0; src_take = 0;
        ctl_vld = 1; ctl_len = LW'(len);
        do @(negedge clk); while (!ctl_rdy);
        @(posedge clk); #1; ctl_vld = 0;
        @(negedge clk);
        chk(tx_req == 1, "R7 announce after control word", tx_req, 1);
        chk(ctl_rdy == 0, "R7 control not ready while busy", ctl_rdy, 0);
        chk(tx_len == LW'(len), "R8 announced length", tx_len, len);
        chk(tx_last == 1 && tx_off == 0, "R8 last=1 offset=0", {tx_last, tx_off}, 256);
        @(negedge clk);
        chk(tx_req == 1 && task_out_rdy == 0, "R8 announce held, no take before grant", {tx_req, task_out_rdy}, 2);
        @(posedge clk); #1; tx_ack = 1;
        @(posedge clk); #1; tx_ack = 0;
        do @(negedge clk); while (tx_req);
        repeat (3) @(negedge clk);
        chk(tx_got.size() == len, "R9 outbound word count", tx_got.size(), len);
        for (int i = 0; i < len && i < tx_got.size(); i++)
            chk(tx_got[i] == DW'(base + i), "R9 outbound word order", tx_got[i], base + i);
        chk(task_out_rdy == 0 && ctl_rdy == 1, "R9 no take after transaction", task_out_rdy, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        task_out_vld = 1;
        @(negedge clk);
        // R1 reset state
        chk(rx_ack == 0 && rx_data_rdy == 0 && task_in_vld == 0, "R1 inbound outputs in reset", rx_ack, 0);
        chk(tx_req == 0 && tx_data_vld == 0 && task_out_rdy == 0, "R1 outbound outputs in reset", tx_req, 0);
        chk(stat_rx_err == 0 && ctl_rdy == 1, "R1 error clear, control ready", {stat_rx_err, ctl_rdy}, 1);
        @(posedge clk); #1; rst_n = 1;

        // table walk: both directions at once (R10)
        for (int v = 0; v < NVEC; v++) begin
            int rl = int'(VEC[v][23:16]);
            int tl = int'(VEC[v][15:8]);
            pat = VEC[v][7:0];
            fork
                rx_txn(rl, v * 3 + 1, v[0], 1000 * (v + 1), 1000);
                tx_txn(tl, 5000 + 100 * v);
            join
            rx_verify(rl, 1000 * (v + 1));
        end

        // R6 zero-length inbound
        pat = 8'hFF;
        rx_txn(0, 7, 1'b0, 0, 1000);
        chk(rx_got.size() == 0, "R6 zero length forwards nothing", rx_got.size(), 0);
        // R9 zero-length outbound
        tx_txn(0, 9000);
        // R4 early end, then the next grant clears the flag
        rx_txn(6, 2, 1'b1, 300, 3);
        rx_verify(3, 300);
        chk(stat_rx_err == 1, "R4 error held while idle", stat_rx_err, 1);
        rx_txn(2, 200, 1'b0, 400, 1000);
        rx_verify(2, 400);
        chk(stat_rx_off == 8'd200, "R5 nonzero offset, data in order", stat_rx_off, 200);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule